// File: doc/BRIEF.md
# Validated Message Word Buffer with Wraparound

This block holds the data words of one serial-bus message between the bus-side word engine and a 16-bit parallel subsystem port. Words received from the bus are written into a 32-entry store and stay there until the bus side signals that the whole message checked out. Only then are they streamed to the subsystem, one word every eight clocks, which is 500 ns at a 16 MHz clock. A message that ends with an error releases nothing. For transmit messages the subsystem first loads words into the same store at no more than one word per sixteen clocks (1 µs at 16 MHz). The bus side then reads them out in order.

Two mode inputs change this flow. With the bypass input high, each received word is also handed to the subsystem on the cycle after it arrives, and validation releases nothing further. With the wraparound input high, a receive message addressed to subaddress 30 is kept in the store and never reaches the subsystem. If the very next command is a transmit from subaddress 30, those same words are returned. Any other command discards them.

Top module: `msg_hold_buffer`

## Requirements
- R1: After reset, `sub_rd_vld` and `sub_wr_ack` are low and the store is empty.
- R2: During a receive message without bypass, words accepted on `rx_we` are stored, and nothing reaches the subsystem before `msg_ok`.
- R3: After `msg_ok` ends a non-bypass receive message, the stored words appear on `sub_rd_data` in arrival order. The first word has `sub_rd_vld` high in the second cycle after the `msg_ok` cycle, and each later word follows exactly 8 cycles after the one before.
- R4: A `msg_bad` strobe during a message empties the store, and none of that message's words are released.
- R5: With `bypass_en` high, each received word appears on `sub_rd_data` with `sub_rd_vld` high in the cycle after its `rx_we` cycle. The following `msg_ok` releases nothing more.
- R6: `sub_wr_ack` is high only while `sub_wr_req` is high, and at most once in any 16 cycles. It stays low during a receive message, during a release, and while wraparound data is held. An acknowledged word is appended to the store.
- R7: The store holds at most 32 words. Words received or offered beyond that are dropped, and only 32 are released.
- R8: During a transmit message, `tx_data` shows the stored words in order. The command strobe resets the position to the first word, and each `tx_re` pulse advances it by one.
- R9: With `wrap_en` high, a receive message to subaddress 30 (`cmd_sa` = 5'd30) is kept after `msg_ok` and never reaches the subsystem.
- R10: If the next command after such a message is a transmit (`cmd_tx` = 1) from subaddress 30, `tx_data` returns the kept words unchanged and in order.
- R11: If the next command after such a message is anything else, the kept words are discarded and the store starts empty.
- R12: The end of a transmit message, whether by `msg_ok` or `msg_bad`, empties the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | A new command starts a message |
| cmd_tx | input | 1 | Command direction: 1 transmit, 0 receive |
| cmd_sa | input | 5 | Command subaddress |
| rx_we | input | 1 | Received data word strobe |
| rx_data | input | 16 | Received data word |
| msg_ok | input | 1 | Message ended and validated |
| msg_bad | input | 1 | Message ended with an error |
| tx_re | input | 1 | Bus side consumed the current transmit word |
| tx_data | output | 16 | Current transmit word |
| bypass_en | input | 1 | Pass received words on at once |
| wrap_en | input | 1 | Enable wraparound at subaddress 30 |
| sub_rd_vld | output | 1 | Word valid for the subsystem |
| sub_rd_data | output | 16 | Word to the subsystem |
| sub_wr_req | input | 1 | Subsystem offers a transmit word |
| sub_wr_data | input | 16 | Offered transmit word |
| sub_wr_ack | output | 1 | Offered word taken this cycle |

## Verification
The assertions check on every cycle that the fill count stays within capacity, that acknowledges and released words never come on back-to-back cycles, that an error leaves the store empty with no release pending, that held wraparound data never produces a subsystem strobe, and that entering wraparound transmit keeps the fill count. Only the bench scenarios can show that released and returned words keep their order and values, that the 8-cycle cadence starts at the right cycle, that bypass forwards each word on time, and that a flush really empties the store. The bench shows the flush through a following load and transmit.

// File: rtl/msg_hold_buffer.sv
module msg_hold_buffer #(
  parameter int DW      = 16,
  parameter int DEPTH   = 32,
  parameter int RD_GAP  = 8,
  parameter int WR_GAP  = 16,
  parameter int SA_W    = 5,
  parameter int WRAP_SA = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_stb,
  input  logic          cmd_tx,
  input  logic [SA_W-1:0] cmd_sa,
  input  logic          rx_we,
  input  logic [DW-1:0] rx_data,
  input  logic          msg_ok,
  input  logic          msg_bad,
  input  logic          tx_re,
  output logic [DW-1:0] tx_data,
  input  logic          bypass_en,
  input  logic          wrap_en,
  output logic          sub_rd_vld,
  output logic [DW-1:0] sub_rd_data,
  input  logic          sub_wr_req,
  input  logic [DW-1:0] sub_wr_data,
  output logic          sub_wr_ack
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int RGW = $clog2(RD_GAP);
  localparam int WGW = $clog2(WR_GAP);

  logic [DW-1:0]  mem [DEPTH];
  logic [CW-1:0]  wptr, rel_left;
  logic [AW-1:0]  rptr, tptr;
  logic [RGW-1:0] rdiv;
  logic [WGW-1:0] wgap;
  logic rx_act, tx_on, wrap_rx, wrap_tx, hold;

  wire not_full = wptr < CW'(DEPTH);
  wire is_wsa   = cmd_sa == SA_W'(WRAP_SA);
  wire rx_take  = rx_act && rx_we && not_full;
  wire rel_fire = (rel_left != '0) && (rdiv == '0);
  wire ld_ok    = !rx_act && (rel_left == '0) && !hold && !wrap_tx && not_full && (wgap == '0);

  assign sub_wr_ack = sub_wr_req && ld_ok;
  assign tx_data    = mem[tptr];

  always_ff @(posedge clk) begin
    if (rx_take)         mem[wptr[AW-1:0]] <= rx_data;
    else if (sub_wr_ack) mem[wptr[AW-1:0]] <= sub_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rel_left <= '0; rptr <= '0; tptr <= '0;
      rdiv <= '0; wgap <= '0;
      rx_act <= 1'b0; tx_on <= 1'b0; wrap_rx <= 1'b0; wrap_tx <= 1'b0; hold <= 1'b0;
      sub_rd_vld <= 1'b0; sub_rd_data <= '0;
    end else begin
      sub_rd_vld <= 1'b0;
      if (rel_fire) begin
        sub_rd_vld  <= 1'b1;
        sub_rd_data <= mem[rptr];
        rptr        <= rptr + 1'b1;
        rel_left    <= rel_left - 1'b1;
        rdiv        <= RGW'(RD_GAP - 1);
      end else if (rdiv != '0) begin
        rdiv <= rdiv - 1'b1;
      end

      if (sub_wr_ack) begin
        wptr <= wptr + 1'b1;
        wgap <= WGW'(WR_GAP - 1);
      end else if (wgap != '0) begin
        wgap <= wgap - 1'b1;
      end

      if (tx_re && tx_on) tptr <= tptr + 1'b1;

      if (cmd_stb) begin
        tptr    <= '0;
        hold    <= 1'b0;
        wrap_tx <= 1'b0;
        if (!cmd_tx) begin
          rx_act   <= 1'b1;
          tx_on    <= 1'b0;
          wrap_rx  <= wrap_en && is_wsa;
          wptr     <= '0;
          rel_left <= '0;
        end else begin
          rx_act  <= 1'b0;
          tx_on   <= 1'b1;
          wrap_rx <= 1'b0;
          if (hold) begin
            if (is_wsa) wrap_tx <= 1'b1;
            else        wptr    <= '0;
          end
        end
      end

      if (rx_take) begin
        wptr <= wptr + 1'b1;
        if (bypass_en && !wrap_rx) begin
          sub_rd_vld  <= 1'b1;
          sub_rd_data <= rx_data;
        end
      end

      if (msg_ok) begin
        if (rx_act) begin
          rx_act  <= 1'b0;
          wrap_rx <= 1'b0;
          if (wrap_rx) begin
            hold <= 1'b1;
          end else begin
            wptr <= '0;
            if (!bypass_en) begin
              rel_left <= wptr;
              rptr     <= '0;
              rdiv     <= '0;
            end
          end
        end else if (tx_on) begin
          tx_on   <= 1'b0;
          wrap_tx <= 1'b0;
          wptr    <= '0;
        end
      end

      if (msg_bad && (rx_act || tx_on)) begin
        rx_act <= 1'b0; tx_on <= 1'b0; wrap_rx <= 1'b0; wrap_tx <= 1'b0;
        hold <= 1'b0; wptr <= '0;
      end
    end
  end

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= CW'(DEPTH));

  p_ack_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sub_wr_ack |=> !sub_wr_ack);

  p_release_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_fire && !cmd_stb) |=> ##1 !sub_rd_vld);

  p_error_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_bad && rx_act && !rx_we) |=> (wptr == '0 && rel_left == '0 && !sub_rd_vld));

  p_wrap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !sub_rd_vld);

  p_wrap_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_tx) |-> wptr == $past(wptr));
endmodule

// File: tb/test_msg_hold_buffer.sv
module test_msg_hold_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_stb = 0, cmd_tx = 0, rx_we = 0, msg_ok = 0, msg_bad = 0, tx_re = 0;
  logic bypass_en = 0, wrap_en = 0, sub_wr_req = 0;
  logic [4:0] cmd_sa = '0;
  logic [15:0] rx_data = '0, sub_wr_data = '0;
  logic [15:0] tx_data, sub_rd_data;
  logic sub_rd_vld, sub_wr_ack;

  msg_hold_buffer i_msg_hold_buffer (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_tx(cmd_tx), .cmd_sa(cmd_sa),
    .rx_we(rx_we), .rx_data(rx_data), .msg_ok(msg_ok), .msg_bad(msg_bad),
    .tx_re(tx_re), .tx_data(tx_data), .bypass_en(bypass_en), .wrap_en(wrap_en),
    .sub_rd_vld(sub_rd_vld), .sub_rd_data(sub_rd_data),
    .sub_wr_req(sub_wr_req), .sub_wr_data(sub_wr_data), .sub_wr_ack(sub_wr_ack));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  string cur_req = "R1";

  int m_buf[$], m_rel[$];
  int m_div, m_gap, m_trd;
  bit m_rxact, m_txon, m_wrx, m_wtx, m_hold, m_was_hold;
  bit e_vld;
  int e_dout;

  function automatic bit exp_ack();
    return sub_wr_req && !m_rxact && m_rel.size() == 0 && !m_hold && !m_wtx &&
           m_buf.size() < 32 && m_gap == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_buf.delete(); m_rel.delete();
      m_div = 0; m_gap = 0; m_trd = 0;
      m_rxact = 0; m_txon = 0; m_wrx = 0; m_wtx = 0; m_hold = 0;
      e_vld = 0; e_dout = 0;
    end else begin
      bit ack;
      ack = exp_ack();
      e_vld = 0;
      if (m_rel.size() > 0) begin
        if (m_div == 0) begin e_vld = 1; e_dout = m_rel.pop_front(); m_div = 7; end
        else m_div--;
      end
      if (ack) begin m_buf.push_back(int'(sub_wr_data)); m_gap = 15; end
      else if (m_gap > 0) m_gap--;
      if (tx_re && m_txon) m_trd++;
      if (cmd_stb) begin
        m_trd = 0; m_was_hold = m_hold; m_hold = 0; m_wtx = 0;
        if (!cmd_tx) begin
          m_rxact = 1; m_txon = 0; m_wrx = wrap_en && cmd_sa == 5'd30;
          m_buf.delete(); m_rel.delete();
        end else begin
          m_rxact = 0; m_txon = 1; m_wrx = 0;
          if (m_was_hold) begin
            if (cmd_sa == 5'd30) m_wtx = 1; else m_buf.delete();
          end
        end
      end
      if (rx_we && m_rxact && m_buf.size() < 32) begin
        m_buf.push_back(int'(rx_data));
        if (bypass_en && !m_wrx) begin e_vld = 1; e_dout = int'(rx_data); end
      end
      if (msg_ok) begin
        if (m_rxact) begin
          m_rxact = 0;
          if (m_wrx) m_hold = 1;
          else begin
            if (!bypass_en) begin m_rel = m_buf; m_div = 0; end
            m_buf.delete();
          end
          m_wrx = 0;
        end else if (m_txon) begin
          m_txon = 0; m_wtx = 0; m_buf.delete();
        end
      end
      if (msg_bad && (m_rxact || m_txon)) begin
        m_rxact = 0; m_txon = 0; m_wrx = 0; m_wtx = 0; m_hold = 0; m_buf.delete();
      end
    end
  end

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      check("sub_rd_vld", int'(sub_rd_vld), int'(e_vld));
      if (e_vld) check("sub_rd_data", int'(sub_rd_data), e_dout);
      check("sub_wr_ack", int'(sub_wr_ack), int'(exp_ack()));
      if (m_txon && m_trd < m_buf.size()) check("tx_data", int'(tx_data), m_buf[m_trd]);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic cmd(bit tx, int sa);
    cmd_stb = 1; cmd_tx = tx; cmd_sa = 5'(sa); @(negedge clk); cmd_stb = 0;
  endtask
  task automatic rxw(int d);
    rx_we = 1; rx_data = 16'(d); @(negedge clk); rx_we = 0;
  endtask
  task automatic ok();
    msg_ok = 1; @(negedge clk); msg_ok = 0;
  endtask
  task automatic err();
    msg_bad = 1; @(negedge clk); msg_bad = 0;
  endtask
  task automatic rd(int n);
    for (int i = 0; i < n; i++) begin tx_re = 1; @(negedge clk); end
    tx_re = 0;
  endtask
  task automatic load(int d);
    bit got = 0;
    sub_wr_req = 1; sub_wr_data = 16'(d);
    while (!got) begin #4 got = sub_wr_ack; @(negedge clk); end
    sub_wr_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL %s watchdog: actual=timeout expected=finish", cur_req);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1;
    cur_req = "R1"; idle(5);
    cur_req = "R2"; cmd(0, 3);
    sub_wr_req = 1;
    for (int i = 0; i < 4; i++) rxw(16'h1100 + i);
    idle(3); sub_wr_req = 0;
    cur_req = "R3"; ok(); idle(40);
    cur_req = "R4"; cmd(0, 3); rxw(16'hbad0); rxw(16'hbad1); rxw(16'hbad2); err(); idle(30);
    cur_req = "R5"; bypass_en = 1; cmd(0, 9);
    rxw(16'h5a01); idle(2); rxw(16'h5a02); rxw(16'h5a03); ok(); idle(10); bypass_en = 0;
    cur_req = "R6"; for (int i = 0; i < 5; i++) load(16'h6600 + i);
    cur_req = "R8"; cmd(1, 4); idle(1); rd(2); idle(2); rd(3);
    cur_req = "R12"; ok(); idle(3);
    cur_req = "R7"; cmd(0, 2); for (int i = 0; i < 34; i++) rxw(16'h7000 + i); ok(); idle(32*8 + 6);
    cur_req = "R9"; wrap_en = 1; cmd(0, 30); rxw(16'hc0de); rxw(16'hbeef); rxw(16'h0042);
    ok(); sub_wr_req = 1; idle(20); sub_wr_req = 0;
    cur_req = "R10"; cmd(1, 30); rd(3); ok(); idle(3);
    cur_req = "R11"; cmd(0, 30); rxw(16'h1234); rxw(16'h5678); ok(); idle(4);
    cmd(1, 7); load(16'h9abc); idle(2); rd(1); ok(); idle(3);
    cur_req = "R12"; load(16'h4444); cmd(1, 5); rd(1); err(); idle(20);
    wrap_en = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule